// File: doc/BRIEF.md
# Amplitude-Indexed Gain Predistorter

This block linearises a power amplifier by pre-scaling each real, signed sample bound for the DAC. The magnitude of the sample picks one entry of a coefficient table. The sample is multiplied by that entry, and the product becomes the drive sample. Each entry is the ratio between the input the amplifier actually needs and the sample value. The amplifier followed by this block therefore behaves as a linear gain stage.

The correction depends on amplitude only. No phase is rotated, because the multi-carrier single-sideband traffic it serves is treated as insensitive to phase. A host computes, smooths and normalises the coefficients and loads them through a simple write port. The block runs at the full interpolated sample rate, one sample per clock.

Top module: `lut_predistorter`

## Requirements
- R1: While reset is held, and after its release until the first accepted sample has crossed the pipe, `out_valid` is 0 and `out_sample` is 0.
- R2: A sample accepted with `in_valid` high on clock edge n gives `out_valid` high after edge n+3. Gaps in `in_valid` are reproduced exactly at the output.
- R3: The table index is the 15-bit magnitude |x| shifted right by (15 − IDX_W). With the default IDX_W = 10 this is |x| / 32. A sample x and its negation −x use the same entry.
- R4: An input of −32768 (0x8000) is first replaced by −32767, both for the index and for the multiply.
- R5: Coefficients are unsigned with 2 integer and 14 fraction bits (16384 = 1.0). The output is floor((x·c + 8192) / 16384), which rounds halves toward +∞.
- R6: A result above +32767 is clamped to +32767, and a result below −32767 is clamped to −32767. The code 0x8000 is never produced.
- R7: Only amplitude is altered: a nonzero output always has the sign of its input, and a zero coefficient yields 0.
- R8: A table write on edge n is seen by samples accepted on edge n or later. A sample accepted on edge n−1 whose read coincides with that write still uses the previous value.
- R9: Coefficients of 2.0 and above (bit 15 set, up to 0xFFFF ≈ 3.9999) are treated as unsigned gains, not as negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample qualifier, in_valid delayed by 3 |
| out_sample | output | 16 | Signed predistorted sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_index | input | IDX_W (10) | Coefficient write address |
| cw_value | input | 16 | Unsigned Q2.14 coefficient |

## Verification
The table is filled with a gently varying gain curve and then driven with several input patterns:
- Back-to-back and gapped known values probe the pipeline depth and the bubble pattern.
- Mirrored ±x pairs and pairs that straddle a 32-code bucket boundary show whether the index uses the magnitude and the right bits.
- Odd samples with a 1.5 gain expose the rounding direction on both signs.
- Gains of 2.0 and 3.9999 at the top of the range separate unsigned from signed coefficient handling and exercise the clamp.
- A long pseudo-random stream with random gaps, with writes landing in the same cycle as, and one cycle after, a matching sample, checks which table value a read in flight sees.

// File: rtl/lutpd_pkg.sv
package lutpd_pkg;
  localparam int SMP_W     = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int MAG_W     = SMP_W - 1;
  localparam int PROD_W    = SMP_W + COEF_W + 1;

  typedef logic signed [SMP_W-1:0] sample_t;
  typedef logic [COEF_W-1:0]       coef_t;
  typedef logic [MAG_W-1:0]        mag_t;

  localparam sample_t SMP_MAX = sample_t'((2 ** (SMP_W - 1)) - 1);
  localparam sample_t SMP_MIN = ~SMP_MAX;

  localparam logic signed [PROD_W-1:0] PROD_HALF = PROD_W'(2 ** (COEF_FRAC - 1));
  localparam logic signed [PROD_W-1:0] PROD_HI   = PROD_W'(SMP_MAX);
  localparam logic signed [PROD_W-1:0] PROD_LO   = -PROD_HI;

  // Fold the one asymmetric code onto the symmetric range.
  function automatic sample_t clamp_floor(input sample_t x);
    return (x == SMP_MIN) ? -SMP_MAX : x;
  endfunction

  // Magnitude of an already clamped sample; always fits MAG_W bits.
  function automatic mag_t magnitude(input sample_t x);
    sample_t a;
    a = x[SMP_W-1] ? -x : x;
    return a[MAG_W-1:0];
  endfunction

  // Signed sample times unsigned Q2.14 gain, round half up, clamp symmetric.
  function automatic sample_t scale_round_sat(input sample_t x, input coef_t c);
    logic signed [PROD_W-1:0] xe;
    logic signed [PROD_W-1:0] ce;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    xe   = PROD_W'(x);
    ce   = signed'(PROD_W'(c));
    prod = xe * ce;
    rnd  = (prod + PROD_HALF) >>> COEF_FRAC;
    if (rnd > PROD_HI)      return SMP_MAX;
    else if (rnd < PROD_LO) return -SMP_MAX;
    else                    return sample_t'(rnd);
  endfunction
endpackage

// File: rtl/lutpd_addr_stage.sv
module lutpd_addr_stage
  import lutpd_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  sample_t          sample_i,
  output logic             valid_o,
  output sample_t          sample_o,
  output logic [IDX_W-1:0] addr_o
);
  sample_t          clamped;
  mag_t             mag;
  logic [IDX_W-1:0] index;

  assign clamped = clamp_floor(sample_i);
  assign mag     = magnitude(clamped);

  generate
    if (IDX_W == MAG_W) begin : g_full_index
      assign index = mag;
    end else begin : g_top_bits
      assign index = mag[MAG_W-1 -: IDX_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      addr_o   <= '0;
    end else begin
      valid_o  <= valid_i;
      sample_o <= clamped;
      addr_o   <= index;
    end
  end

  // R4: the most negative code never travels down the pipe
  a_r4_min_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sample_i == SMP_MIN) |=> (sample_o == -SMP_MAX));

  // R3: mirrored samples land on one entry (index depends on magnitude only)
  a_r3_index_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && $past(valid_i) && sample_i == -$past(sample_i) && sample_i != SMP_MIN
     && $past(sample_i) != SMP_MIN) |=> (addr_o == $past(addr_o)));
endmodule

// File: rtl/lutpd_coef_table.sv
module lutpd_coef_table
  import lutpd_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  sample_t          sample_i,
  input  logic [IDX_W-1:0] raddr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  coef_t            wdata_i,
  output logic             valid_o,
  output sample_t          sample_o,
  output coef_t            coef_o
);
  localparam int DEPTH = 1 << IDX_W;

  coef_t mem [DEPTH];

  // Read-first array: a same-edge write is not visible to this read.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    coef_o <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o  <= valid_i;
      sample_o <= sample_i;
    end
  end

  // R8: a write is stored by the next edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/lutpd_scale_stage.sv
module lutpd_scale_stage
  import lutpd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid_i,
  input  sample_t sample_i,
  input  coef_t   coef_i,
  output logic    valid_o,
  output sample_t sample_o
);
  sample_t scaled;

  assign scaled = scale_round_sat(sample_i, coef_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o  <= valid_i;
      sample_o <= valid_i ? scaled : '0;
    end
  end

  // R6: symmetric clamp, 0x8000 never leaves
  a_r6_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sample_o != SMP_MIN));

  // R7: sign of a nonzero result follows the input
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && sample_o != '0) |-> (sample_o[SMP_W-1] == $past(sample_i[SMP_W-1])));

  // R7: zero gain gives zero drive
  a_r7_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && coef_i == '0) |=> (sample_o == '0));
endmodule

// File: rtl/lut_predistorter.sv
module lut_predistorter
  import lutpd_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] out_sample,
  input  logic                    cw_en,
  input  logic [IDX_W-1:0]        cw_index,
  input  logic [COEF_W-1:0]       cw_value
);
  logic             s1_valid;
  sample_t          s1_sample;
  logic [IDX_W-1:0] s1_addr;
  logic             s2_valid;
  sample_t          s2_sample;
  coef_t            s2_coef;

  lutpd_addr_stage #(.IDX_W(IDX_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (in_valid),
    .sample_i (in_sample),
    .valid_o  (s1_valid),
    .sample_o (s1_sample),
    .addr_o   (s1_addr)
  );

  lutpd_coef_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (s1_valid),
    .sample_i (s1_sample),
    .raddr_i  (s1_addr),
    .we_i     (cw_en),
    .waddr_i  (cw_index),
    .wdata_i  (cw_value),
    .valid_o  (s2_valid),
    .sample_o (s2_sample),
    .coef_o   (s2_coef)
  );

  lutpd_scale_stage u_scale (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (s2_valid),
    .sample_i (s2_sample),
    .coef_i   (s2_coef),
    .valid_o  (out_valid),
    .sample_o (out_sample)
  );

  // Edges seen since reset release, saturating; gates the latency property.
  logic [1:0] live_edges;
  always_ff @(posedge clk) begin
    if (!rst_n)                live_edges <= '0;
    else if (live_edges != 2'd3) live_edges <= live_edges + 2'd1;
  end

  // R2: three-clock latency, bubbles preserved
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (live_edges == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1: idle output is quiet
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_sample == '0));
endmodule

// File: tb/lut_predistorter_tb.sv
module lut_predistorter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam int BUCKET = 32768 >> IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic              out_valid;
  logic signed [15:0] out_sample;
  logic              cw_en = 1'b0;
  logic [IDX_W-1:0]  cw_index = '0;
  logic [15:0]       cw_value = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_predistorter #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample),
    .cw_en(cw_en), .cw_index(cw_index), .cw_value(cw_value)
  );

  typedef struct {
    int    exp;
    int    due;
    string req;
  } item_t;

  item_t q[$];
  int    shadow [1 << IDX_W];
  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  int unsigned lfsr = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference: written from the requirements, floor division done by hand.
  function automatic int model(input int x, input int c);
    int     xs;
    longint p;
    longint r;
    xs = (x < -32767) ? -32767 : x;
    p  = longint'(xs) * longint'(c) + 64'sd8192;
    if (p >= 0) r = p / 16384;
    else        r = -((-p + 16383) / 16384);
    if (r > 32767)  r = 32767;
    if (r < -32767) r = -32767;
    return int'(r);
  endfunction

  function automatic int index_of(input int x);
    int xs;
    xs = (x < -32767) ? -32767 : x;
    if (xs < 0) xs = -xs;
    return xs / BUCKET;
  endfunction

  function automatic int rnd();
    lfsr ^= lfsr << 13;
    lfsr ^= lfsr >> 17;
    lfsr ^= lfsr << 5;
    return int'(lfsr & 32'h7fff_ffff);
  endfunction

  // One clock of stimulus; the write is applied to the shadow before the
  // sample looks it up, matching R8 (same-edge write is seen).
  task automatic step(input bit v, input int x, input bit we, input int wa,
                      input int wc, input string req);
    item_t it;
    @(negedge clk);
    if (we) shadow[wa] = wc;
    if (v) begin
      it.exp = model(x, shadow[index_of(x)]);
      it.due = cyc + 3;
      it.req = req;
      q.push_back(it);
    end
    in_valid  = v;
    in_sample = 16'(x);
    cw_en     = we;
    cw_index  = IDX_W'(wa);
    cw_value  = 16'(wc);
  endtask

  task automatic send(input int x, input string req);
    step(1'b1, x, 1'b0, 0, 0, req);
  endtask

  task automatic write(input int a, input int c);
    step(1'b0, 0, 1'b1, a, c, "R8");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 0, "");
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R2 unexpected out_valid", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check({it.req, " timing (R2)"}, cyc, it.due);
          check(it.req, int'(out_sample), it.exp);
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        check("R2 missing out_valid", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_sample in reset", int'(out_sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_sample after reset", int'(out_sample), 0);

    // Gain curve around unity
    for (int i = 0; i < (1 << IDX_W); i++)
      write(i, 16384 + ((i * 37) % 4096) - 2048);
    idle(2);

    // R3 R4 R5: known values back to back
    send(0, "R5");
    send(1000, "R5");
    send(-1000, "R3");
    send(32767, "R5");
    send(-32767, "R3");
    send(-32768, "R4");
    send(12345, "R5");
    send(-23456, "R5");
    send(6431, "R3");   // last code of bucket 200
    send(6432, "R3");   // first code of bucket 201
    idle(4);

    // R2: gapped stream
    for (int i = 0; i < 12; i++) begin
      send(i * 2500 - 14000, "R2");
      idle(i % 3);
    end
    idle(4);

    // R5: rounding with gain 1.5 on bucket 0
    write(0, 24576);
    send(1, "R5");    // 1.5  -> 2
    send(-1, "R5");   // -1.5 -> -1
    send(3, "R5");    // 4.5  -> 5
    send(-3, "R5");   // -4.5 -> -4
    idle(4);

    // R9 R6: large unsigned gains
    write(500, 32768);
    write(1000, 32768);
    write(1023, 65535);
    send(16000, "R9");   // 2.0 * 16000 = 32000
    send(-16000, "R9");
    send(32000, "R6");   // 64000 clamps
    send(-32000, "R6");
    send(32767, "R6");
    send(-32768, "R6");
    idle(4);

    // R7: zero gain
    write(50, 0);
    send(1600, "R7");
    send(-1600, "R7");
    idle(4);

    // R8: write landing with a matching sample
    write(300, 20000);
    step(1'b1, 9600, 1'b1, 300, 12000, "R8 same-edge write");   // new value
    step(1'b1, 9600, 1'b0, 0, 0, "R8 after write");
    send(9610, "R8 old value in flight");
    write(300, 30000);                                         // read-first
    send(-9600, "R8 new value");
    idle(4);

    // R7 R2: random stream with gaps and occasional writes
    for (int i = 0; i < 400; i++) begin
      int x;
      x = (rnd() % 65536) - 32768;
      if (rnd() % 8 == 0)
        step(1'b1, x, 1'b1, rnd() % (1 << IDX_W), rnd() % 65536, "R7 random");
      else
        send(x, "R7 random");
      if (rnd() % 4 == 0) idle(1);
    end
    idle(6);

    check("R2 queue drained", q.size(), 0);
    finish_run();
  end
endmodule